// File: doc/BRIEF.md
# Transceiver Diagnostic Alarm Flag Generator

This block turns the latest diagnostic measurements of an optical transceiver into the alarm and warning flag bytes of the module's diagnostic register space. There are seven measurements: temperature, supply voltage, transmit bias, transmit power, receive power, and optionally laser temperature and thermo-electric cooler current. Each one is compared with four programmable limits: a high alarm, a low alarm, a high warning and a low warning. Some measurements are signed and some are unsigned, and each is compared in its own signedness.

The conversion logic presents a new set of measurements together with a one-cycle update strobe. On that strobe the block captures the measurements and the freshly computed flags together. The captured values are then visible through a byte-wide read port, which serves the measurement byte window and the four flag bytes. Between strobes everything a reader sees is held, so a read never mixes two updates. The limits sit in a small register bank that is filled through a byte-wide write port.

Top module: `ddm_alarm_flags`

## Requirements
- R1: After reset, every read address returns 0x00, and all stored limits are zero.
- R2: Alarm byte address 112 and warning byte address 116 share one layout, from bit 7 down to bit 0: temperature high, temperature low, supply high, supply low, bias high, bias low, TX power high, TX power low.
- R3: Alarm byte address 113 and warning byte address 117 share one layout: bit 7 is RX power high, bit 6 RX power low, bit 5 laser temperature high, bit 4 laser temperature low, bit 3 cooler current high, bit 2 cooler current low. Bits 1 and 0 always read 0.
- R4: A high flag is set only when the value is strictly greater than its high limit. A low flag is set only when the value is strictly less than its low limit. A value equal to a limit sets no flag.
- R5: Temperature (index 0), laser temperature (index 5) and cooler current (index 6) are compared as 16-bit two's complement numbers.
- R6: Supply (index 1), bias (index 2), TX power (index 3) and RX power (index 4) are compared as 16-bit unsigned numbers.
- R7: Measurement index i is read big-endian. Its upper byte is at address 96+2i and its lower byte at 97+2i. The index order is temperature, supply, bias, TX power, RX power, laser temperature, cooler current.
- R8: Flags and measurement bytes change only on a clock edge where upd_strobe is high. Limit writes and changes on meas_in between strobes leave every read value unchanged.
- R9: When opt_en is 0 at a strobe, bits 5 to 2 of bytes 113 and 117 are captured as 0, whatever the optional measurements and limits are.
- R10: The limit bank is written one byte per cycle at byte address 8*i + 2*k + b. Here i is the measurement index, k is the limit kind (0 high alarm, 1 low alarm, 2 high warning, 3 low warning), and b=0 selects the upper byte. Writes to addresses 56 to 63 have no effect.
- R11: Read addresses outside 96–109, 112, 113, 116 and 117 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_strobe | input | 1 | One-cycle strobe that captures the measurements and the flags |
| opt_en | input | 1 | Enables the laser temperature and cooler current flags |
| meas_in | input | 7x16 | Measurements, indexed as in R7 |
| thr_wr_en | input | 1 | Limit bank write enable |
| thr_wr_addr | input | 6 | Limit bank byte address, per R10 |
| thr_wr_data | input | 8 | Limit bank write data |
| rd_addr | input | 8 | Diagnostic space read address |
| rd_data | output | 8 | Read data for rd_addr, combinational from the held state |

## Verification
Directed cases set each measurement exactly equal to all four of its limits, which separates a strict comparison from an inclusive one. A value of 0xFFFF is checked against small positive limits: a signed comparison reads it as -1 and an unsigned comparison reads it as 65535, so a measurement decoded with the wrong signedness shows up. Hold cases write limits and change the inputs between strobes, which separates a captured update from one that runs through live. Cases with opt_en low separate optional flags that are forced to zero from ones that are computed. Random measurements and limits at a fixed seed, with a random opt_en, check every flag bit and window byte against a model of the bit layout.

// File: rtl/ddm_pkg.sv
package ddm_pkg;
    localparam int MEAS_W     = 16;
    localparam int NUM_MEAS   = 7;
    localparam int THR_KINDS  = 4;
    localparam int BYTES_PER  = MEAS_W / 8;
    localparam int THR_BYTES  = NUM_MEAS * THR_KINDS * BYTES_PER;
    localparam int THR_AW     = $clog2(THR_BYTES);
    localparam int RD_AW      = 8;

    localparam int ADDR_MEAS_BASE = 96;
    localparam int ADDR_ALM0      = 112;
    localparam int ADDR_ALM1      = 113;
    localparam int ADDR_WRN0      = 116;
    localparam int ADDR_WRN1      = 117;

    typedef enum logic [2:0] {
        M_TEMP, M_VCC, M_BIAS, M_TXP, M_RXP, M_LTEMP, M_TEC
    } meas_e;

    typedef enum logic [1:0] {
        K_HI_ALM, K_LO_ALM, K_HI_WRN, K_LO_WRN
    } kind_e;

    // measurement indices compared as two's complement
    localparam logic [NUM_MEAS-1:0] SIGNED_MASK   = 7'b1100001;
    // measurement indices gated by opt_en
    localparam logic [NUM_MEAS-1:0] OPTIONAL_MASK = 7'b1100000;

    typedef struct packed {
        logic hi_alm;
        logic lo_alm;
        logic hi_wrn;
        logic lo_wrn;
    } flags_t;

    typedef struct packed {
        logic [7:0] alm0;
        logic [7:0] alm1;
        logic [7:0] wrn0;
        logic [7:0] wrn1;
    } flag_bytes_t;

    function automatic logic above(input logic [MEAS_W-1:0] v,
                                   input logic [MEAS_W-1:0] t,
                                   input logic sgn);
        if (sgn) return $signed(v) > $signed(t);
        return v > t;
    endfunction

    function automatic logic below(input logic [MEAS_W-1:0] v,
                                   input logic [MEAS_W-1:0] t,
                                   input logic sgn);
        if (sgn) return $signed(v) < $signed(t);
        return v < t;
    endfunction

    function automatic flag_bytes_t pack_flags(input flags_t [NUM_MEAS-1:0] f,
                                               input logic opt_en);
        flag_bytes_t r;
        flags_t [NUM_MEAS-1:0] g;
        for (int i = 0; i < NUM_MEAS; i++) begin
            g[i] = (OPTIONAL_MASK[i] && !opt_en) ? flags_t'(0) : f[i];
        end
        r.alm0 = {g[M_TEMP].hi_alm, g[M_TEMP].lo_alm, g[M_VCC].hi_alm, g[M_VCC].lo_alm,
                  g[M_BIAS].hi_alm, g[M_BIAS].lo_alm, g[M_TXP].hi_alm, g[M_TXP].lo_alm};
        r.alm1 = {g[M_RXP].hi_alm, g[M_RXP].lo_alm, g[M_LTEMP].hi_alm, g[M_LTEMP].lo_alm,
                  g[M_TEC].hi_alm, g[M_TEC].lo_alm, 2'b00};
        r.wrn0 = {g[M_TEMP].hi_wrn, g[M_TEMP].lo_wrn, g[M_VCC].hi_wrn, g[M_VCC].lo_wrn,
                  g[M_BIAS].hi_wrn, g[M_BIAS].lo_wrn, g[M_TXP].hi_wrn, g[M_TXP].lo_wrn};
        r.wrn1 = {g[M_RXP].hi_wrn, g[M_RXP].lo_wrn, g[M_LTEMP].hi_wrn, g[M_LTEMP].lo_wrn,
                  g[M_TEC].hi_wrn, g[M_TEC].lo_wrn, 2'b00};
        return r;
    endfunction
endpackage

// File: rtl/ddm_thresh_bank.sv
module ddm_thresh_bank
    import ddm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [THR_AW-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output logic [NUM_MEAS-1:0][THR_KINDS-1:0][MEAS_W-1:0] thr
);
    logic [7:0] mem [THR_BYTES];
    logic       addr_ok;

    assign addr_ok = wr_addr < THR_AW'(THR_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < THR_BYTES; i++) mem[i] <= 8'h00;
        end else if (wr_en && addr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar m = 0; m < NUM_MEAS; m++) begin : g_meas
        for (genvar k = 0; k < THR_KINDS; k++) begin : g_kind
            localparam int BASE = (m * THR_KINDS + k) * BYTES_PER;
            assign thr[m][k] = {mem[BASE], mem[BASE+1]};
        end
    end

    // R10
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_ok) |=> $stable(thr));
endmodule

// File: rtl/ddm_cmp.sv
module ddm_cmp
    import ddm_pkg::*;
#(
    parameter bit SIGNED_CMP = 1'b0
)(
    input  logic [MEAS_W-1:0]                  val,
    input  logic [THR_KINDS-1:0][MEAS_W-1:0]   thr,
    output flags_t                             flags
);
    always_comb begin
        flags.hi_alm = above(val, thr[K_HI_ALM], SIGNED_CMP);
        flags.lo_alm = below(val, thr[K_LO_ALM], SIGNED_CMP);
        flags.hi_wrn = above(val, thr[K_HI_WRN], SIGNED_CMP);
        flags.lo_wrn = below(val, thr[K_LO_WRN], SIGNED_CMP);
    end

    // R4
    always_comb begin
        equal_sets_nothing_chk: assert (!(val == thr[K_HI_ALM] && flags.hi_alm) &&
                                        !(val == thr[K_LO_ALM] && flags.lo_alm) &&
                                        !(val == thr[K_HI_WRN] && flags.hi_wrn) &&
                                        !(val == thr[K_LO_WRN] && flags.lo_wrn));
    end
endmodule

// File: rtl/ddm_snapshot.sv
module ddm_snapshot
    import ddm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              upd,
    input  logic                              opt_en,
    input  logic [NUM_MEAS-1:0][MEAS_W-1:0]   meas_in,
    input  flags_t [NUM_MEAS-1:0]             flags_in,
    output logic [NUM_MEAS-1:0][MEAS_W-1:0]   meas_q,
    output flag_bytes_t                       fb_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            meas_q <= '0;
            fb_q   <= '0;
        end else if (upd) begin
            meas_q <= meas_in;
            fb_q   <= pack_flags(flags_in, opt_en);
        end
    end

    // R8
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(fb_q) && $stable(meas_q)));

    // R9
    optional_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !opt_en) |=> (fb_q.alm1[5:2] == 4'h0 && fb_q.wrn1[5:2] == 4'h0));
endmodule

// File: rtl/ddm_alarm_flags.sv
module ddm_alarm_flags
    import ddm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              upd_strobe,
    input  logic                              opt_en,
    input  logic [NUM_MEAS-1:0][MEAS_W-1:0]   meas_in,
    input  logic                              thr_wr_en,
    input  logic [THR_AW-1:0]                 thr_wr_addr,
    input  logic [7:0]                        thr_wr_data,
    input  logic [RD_AW-1:0]                  rd_addr,
    output logic [7:0]                        rd_data
);
    logic [NUM_MEAS-1:0][THR_KINDS-1:0][MEAS_W-1:0] thr;
    flags_t [NUM_MEAS-1:0]                          flags;
    logic [NUM_MEAS-1:0][MEAS_W-1:0]                meas_q;
    flag_bytes_t                                    fb_q;

    ddm_thresh_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (thr_wr_en),
        .wr_addr (thr_wr_addr),
        .wr_data (thr_wr_data),
        .thr     (thr)
    );

    for (genvar m = 0; m < NUM_MEAS; m++) begin : g_cmp
        ddm_cmp #(.SIGNED_CMP(SIGNED_MASK[m])) u_cmp (
            .val   (meas_in[m]),
            .thr   (thr[m]),
            .flags (flags[m])
        );
    end

    ddm_snapshot u_snap (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd_strobe),
        .opt_en   (opt_en),
        .meas_in  (meas_in),
        .flags_in (flags),
        .meas_q   (meas_q),
        .fb_q     (fb_q)
    );

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_MEAS; i++) begin
            if (rd_addr == RD_AW'(ADDR_MEAS_BASE + 2*i))     rd_data = meas_q[i][15:8];
            if (rd_addr == RD_AW'(ADDR_MEAS_BASE + 2*i + 1)) rd_data = meas_q[i][7:0];
        end
        case (rd_addr)
            RD_AW'(ADDR_ALM0): rd_data = fb_q.alm0;
            RD_AW'(ADDR_ALM1): rd_data = fb_q.alm1;
            RD_AW'(ADDR_WRN0): rd_data = fb_q.wrn0;
            RD_AW'(ADDR_WRN1): rd_data = fb_q.wrn1;
            default: ;
        endcase
    end

    // R3
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == RD_AW'(ADDR_ALM1) || rd_addr == RD_AW'(ADDR_WRN1)) |-> rd_data[1:0] == 2'b00);

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr < RD_AW'(ADDR_MEAS_BASE) || rd_addr > RD_AW'(ADDR_WRN1)) |-> rd_data == 8'h00);
endmodule

// File: tb/ddm_alarm_flags_tb_top.sv
module ddm_alarm_flags_tb_top;
    logic             clk = 1'b0;
    logic             rst;
    logic             upd_strobe;
    logic             opt_en;
    logic [6:0][15:0] meas_in;
    logic             thr_wr_en;
    logic [5:0]       thr_wr_addr;
    logic [7:0]       thr_wr_data;
    logic [7:0]       rd_addr;
    logic [7:0]       rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_thr [7][4];
    logic [7:0]  exp_mem [256];

    always #4 clk = ~clk;

    ddm_alarm_flags dut_i (
        .clk(clk), .rst(rst), .upd_strobe(upd_strobe), .opt_en(opt_en),
        .meas_in(meas_in), .thr_wr_en(thr_wr_en), .thr_wr_addr(thr_wr_addr),
        .thr_wr_data(thr_wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic bit is_signed_idx(int i);
        return (i == 0 || i == 5 || i == 6);
    endfunction

    function automatic bit gt(logic [15:0] a, logic [15:0] b, bit s);
        return s ? ($signed(a) > $signed(b)) : (a > b);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv, int addr);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, addr, act, expv);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wr_byte(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        thr_wr_en = 1'b1; thr_wr_addr = a; thr_wr_data = d;
        @(negedge clk);
        thr_wr_en = 1'b0;
    endtask

    // R10 address map: 8*i + 2*k + b, b=0 upper byte
    task automatic set_thr(int i, int k, logic [15:0] v);
        wr_byte(6'(8*i + 2*k), v[15:8]);
        wr_byte(6'(8*i + 2*k + 1), v[7:0]);
        m_thr[i][k] = v;
    endtask

    task automatic model_capture(logic [6:0][15:0] mv, bit opt);
        bit h [7][2];
        bit l [7][2];
        for (int i = 0; i < 7; i++) begin
            bit keep;
            keep = opt || (i < 5);
            h[i][0] = keep && gt(mv[i], m_thr[i][0], is_signed_idx(i));
            l[i][0] = keep && gt(m_thr[i][1], mv[i], is_signed_idx(i));
            h[i][1] = keep && gt(mv[i], m_thr[i][2], is_signed_idx(i));
            l[i][1] = keep && gt(m_thr[i][3], mv[i], is_signed_idx(i));
            exp_mem[96 + 2*i] = mv[i][15:8];
            exp_mem[97 + 2*i] = mv[i][7:0];
        end
        for (int w = 0; w < 2; w++) begin
            logic [7:0] b0, b1;
            b0 = {h[0][w], l[0][w], h[1][w], l[1][w], h[2][w], l[2][w], h[3][w], l[3][w]};
            b1 = {h[4][w], l[4][w], h[5][w], l[5][w], h[6][w], l[6][w], 2'b00};
            exp_mem[w ? 116 : 112] = b0;
            exp_mem[w ? 117 : 113] = b1;
        end
    endtask

    task automatic strobe(logic [6:0][15:0] mv, bit opt);
        @(negedge clk);
        meas_in = mv; opt_en = opt; upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
        model_capture(mv, opt);
    endtask

    task automatic check_window(string tag);
        logic [7:0] d;
        for (int a = 96; a <= 117; a++) begin
            rd(8'(a), d);
            check(tag, d, exp_mem[a], a);
        end
    endtask

    task automatic check_byte(string tag, int a, logic [7:0] expv);
        logic [7:0] d;
        rd(8'(a), d);
        check(tag, d, expv, a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [6:0][15:0] mv;
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; upd_strobe = 0; opt_en = 1; meas_in = '0;
        thr_wr_en = 0; thr_wr_addr = 0; thr_wr_data = 0; rd_addr = 0;
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
        for (int i = 0; i < 7; i++) for (int k = 0; k < 4; k++) m_thr[i][k] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every address reads zero after reset
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            check("R1", d, 8'h00, a);
        end

        // R1: zero limits -> any nonzero unsigned value raises its high flags
        mv = '0; mv[1] = 16'h0001;
        strobe(mv, 1'b1);
        check_byte("R1", 112, 8'h20);
        check_byte("R1", 116, 8'h20);

        // R4: every value equal to all four of its limits
        for (int i = 0; i < 7; i++) begin
            mv[i] = 16'h1000 + 16'(i * 16'h0111);
            for (int k = 0; k < 4; k++) set_thr(i, k, mv[i]);
        end
        strobe(mv, 1'b1);
        check_byte("R4", 112, 8'h00);
        check_byte("R4", 113, 8'h00);
        check_byte("R4", 116, 8'h00);
        check_byte("R4", 117, 8'h00);

        // R7: big-endian window
        check_window("R7");

        // R5 / R6: 0xFFFF against high 0x0010, low 0x0000
        for (int i = 0; i < 7; i++) begin
            set_thr(i, 0, 16'h0010); set_thr(i, 1, 16'h0000);
            set_thr(i, 2, 16'h0010); set_thr(i, 3, 16'h0000);
            mv[i] = 16'hFFFF;
        end
        strobe(mv, 1'b1);
        // signed indices give low flags, unsigned give high flags
        check_byte("R5", 112, 8'h6A);   // temp low, vcc/bias/txp high
        check_byte("R6", 116, 8'h6A);
        check_byte("R5", 113, 8'h94);   // rxp high, laser low, tec low
        check_byte("R3", 117, 8'h94);

        // R2 / R3: single-bit positions per flag
        for (int i = 0; i < 7; i++) begin
            set_thr(i, 0, 16'h0100); set_thr(i, 1, 16'h0080);
            set_thr(i, 2, 16'h00F0); set_thr(i, 3, 16'h0090);
        end
        for (int j = 0; j < 7; j++) begin
            for (int i = 0; i < 7; i++) mv[i] = 16'h00C0;
            mv[j] = 16'h0200;
            strobe(mv, 1'b1);
            check_window(j < 4 ? "R2" : "R3");
            for (int i = 0; i < 7; i++) mv[i] = 16'h00C0;
            mv[j] = 16'h0010;
            strobe(mv, 1'b1);
            check_window(j < 4 ? "R2" : "R3");
        end
        // warning only band: above warn high, below alarm high
        for (int i = 0; i < 7; i++) mv[i] = 16'h00F8;
        strobe(mv, 1'b1);
        check_byte("R2", 112, 8'h00);
        check_byte("R2", 116, 8'hAA);
        check_byte("R3", 117, 8'hA8);

        // R9: optional flags forced to zero
        mv[5] = 16'h7000; mv[6] = 16'h8000;
        strobe(mv, 1'b0);
        check_byte("R9", 113, 8'h00);
        check_byte("R9", 117, 8'h80);
        check_window("R9");

        // R8: limit writes and input changes without a strobe
        set_thr(0, 0, 16'h7FFF);
        set_thr(4, 2, 16'hFFFF);
        @(negedge clk);
        meas_in = '1;
        check_window("R8");

        // R10: writes past the bank have no effect
        for (int a = 56; a < 64; a++) wr_byte(6'(a), 8'hFF);
        mv = '0; mv[0] = 16'h0001;
        strobe(mv, 1'b1);
        check_window("R10");

        // R11: unmapped addresses
        check_byte("R11", 0, 8'h00);
        check_byte("R11", 110, 8'h00);
        check_byte("R11", 111, 8'h00);
        check_byte("R11", 114, 8'h00);
        check_byte("R11", 115, 8'h00);
        check_byte("R11", 118, 8'h00);
        check_byte("R11", 255, 8'h00);

        // random mix
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 7; i++) begin
                for (int k = 0; k < 4; k++) set_thr(i, k, 16'($urandom));
                mv[i] = ($urandom_range(0, 3) == 0) ? m_thr[i][$urandom_range(0, 3)]
                                                    : 16'($urandom);
            end
            strobe(mv, 1'($urandom_range(0, 1)));
            check_window("R2");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule